// File: doc/BRIEF.md
# Local-to-PCI Address Window Translator

This block sits between an internal 36-bit bus and a PCI initiator engine. It sends each burst request on the internal bus through four programmable windows. Windows 0, 1 and 2 lead to PCI memory space and window 3 leads to PCI I/O space. Each window has an enable, a power-of-two size, a local base and a PCI base. When a burst falls inside an enabled window, the block returns a 40-bit PCI address. It also returns the command class (memory or I/O) and a flag that marks the access as needing a dual address cycle. When no enabled window matches, a miss is returned so that upstream logic can send the access somewhere else.

Window settings are loaded through a one-cycle write port: a select, an enable bit, a size exponent and two bases. Each result is held by a small state machine. Its states are S_IDLE (no result this cycle), S_HIT (a translated result is presented) and S_MISS (no window matched). The next state is chosen anew from every cycle's request, as follows:
- From any state, a valid burst that matches a window goes to S_HIT.
- A valid burst that matches no window goes to S_MISS.
- No request, or a request that is not a burst, goes to S_IDLE.

Top module: `pci_window_xlate`

## Requirements
- R1: After reset, `out_valid` is 0 and all four windows are disabled, so the first burst request misses.
- R2: A burst hits window w when that window is enabled and the request address equals its local base in every bit at or above bit `size` (the size exponent).
- R3: On a hit, `out_addr` takes bits 39..`size` from the window's PCI base and bits `size`-1..0 from the request address. The bits of the request address at and above `size` are discarded.
- R4: A size exponent below 20 is stored as 20 (1 MiB windows), and one above 36 is stored as 36 (the whole local space).
- R5: When several windows hit, window 0 wins over window 1, window 1 wins over window 2, and window 2 wins over the I/O window 3. `out_win` gives the winning index.
- R6: `out_is_io` is 1 for a hit in window 3 (a PCI I/O command) and 0 for a hit in windows 0 to 2 (a PCI memory command).
- R7: On a hit, `out_dac` is 1 exactly when `out_addr` is greater than 0x00_FFFF_FFFF.
- R8: A valid burst that matches no enabled window gives `out_valid`=1 and `out_miss`=1, with `out_hit`=0.
- R9: A valid request with `req_burst`=0 is not translated: `out_valid` is 0 in the cycle after it.
- R10: The result of a request appears in the cycle after the request. In a cycle that follows no request, `out_valid` is 0.
- R11: Writing a window with `cfg_en`=0 disables it, and a disabled window never hits whatever its base and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_sel | input | 2 | Window index to write (3 = I/O window) |
| cfg_en | input | 1 | Enable value written |
| cfg_size | input | 6 | Size exponent (log2 of the window bytes) |
| cfg_lbase | input | 36 | Local base address |
| cfg_pbase | input | 40 | PCI base address |
| req_valid | input | 1 | Request present |
| req_burst | input | 1 | Request is a burst |
| req_addr | input | 36 | Local request address |
| out_valid | output | 1 | Result present |
| out_hit | output | 1 | Request hit a window |
| out_miss | output | 1 | Request matched no window |
| out_is_io | output | 1 | I/O command (1) or memory command (0) |
| out_win | output | 2 | Winning window index |
| out_dac | output | 1 | Dual address cycle needed |
| out_addr | output | 40 | Translated PCI address |

## Verification
Directed cases cover the following, each telling apart one piece of the design:
- Windows placed above 4 GiB, to check the dual-cycle flag. A window placed below 4 GiB must leave the flag clear.
- Addresses on both sides of a 1 MiB window edge, which tell a correct hit compare from an off-by-one mask.
- Overlapping windows that are disabled one at a time, which expose a wrong priority order and a disabled window that still matches.
- Size values below 20 and above 36, which show whether the size is clamped.

Random cases then reprogram all four windows with random sizes and bases and send addresses. Some addresses are drawn near a window base and others are uniform. This mixes hits, overlaps and misses so that the translated address, the command class and the index can be compared against a separate model.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
    localparam int LA_W    = 36;
    localparam int PA_W    = 40;
    localparam int NWIN    = 4;
    localparam int IO_WIN  = NWIN - 1;
    localparam int WIN_W   = $clog2(NWIN);
    localparam int SZ_W    = 6;
    localparam int MIN_LOG = 20;
    localparam int MAX_LOG = LA_W;

    typedef struct packed {
        logic            en;
        logic [SZ_W-1:0] sz;
        logic [LA_W-1:0] lbase;
        logic [PA_W-1:0] pbase;
    } win_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HIT  = 2'd1,
        S_MISS = 2'd2
    } st_t;
endpackage

// File: rtl/pwx_regs.sv
module pwx_regs
    import pwx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [WIN_W-1:0]     cfg_sel,
    input  logic                 cfg_en,
    input  logic [SZ_W-1:0]      cfg_size,
    input  logic [LA_W-1:0]      cfg_lbase,
    input  logic [PA_W-1:0]      cfg_pbase,
    output win_t [NWIN-1:0]      wins
);
    logic [SZ_W-1:0] size_clamped;

    always_comb begin
        if (cfg_size < SZ_W'(MIN_LOG))
            size_clamped = SZ_W'(MIN_LOG);
        else if (cfg_size > SZ_W'(MAX_LOG))
            size_clamped = SZ_W'(MAX_LOG);
        else
            size_clamped = cfg_size;
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wins[w].en    <= 1'b0;
                wins[w].sz    <= SZ_W'(MIN_LOG);
                wins[w].lbase <= '0;
                wins[w].pbase <= '0;
            end else if (cfg_we && cfg_sel == WIN_W'(w)) begin
                wins[w].en    <= cfg_en;
                wins[w].sz    <= size_clamped;
                wins[w].lbase <= cfg_lbase;
                wins[w].pbase <= cfg_pbase;
            end
        end
    end

    AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wins[0].sz >= SZ_W'(MIN_LOG) && wins[0].sz <= SZ_W'(MAX_LOG)); // R4
endmodule

// File: rtl/pwx_match.sv
module pwx_match
    import pwx_pkg::*;
(
    input  win_t [NWIN-1:0]  wins,
    input  logic [LA_W-1:0]  addr,
    output logic             found,
    output logic [WIN_W-1:0] sel,
    output logic [PA_W-1:0]  sel_addr
);
    logic [NWIN-1:0] hit;
    logic [PA_W-1:0] xaddr [NWIN];
    logic [PA_W-1:0] offm  [NWIN];

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        assign offm[w]  = (PA_W'(1) << wins[w].sz) - PA_W'(1);
        assign hit[w]   = wins[w].en &&
                          (((PA_W'(addr) ^ PA_W'(wins[w].lbase)) & ~offm[w]) == '0);
        assign xaddr[w] = (wins[w].pbase & ~offm[w]) | (PA_W'(addr) & offm[w]);
    end

    always_comb begin
        found    = |hit;
        sel      = '0;
        sel_addr = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit[w]) begin
                sel      = WIN_W'(w);
                sel_addr = xaddr[w];
            end
        end
    end
endmodule

// File: rtl/pci_window_xlate.sv
module pci_window_xlate
    import pwx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic              cfg_en,
    input  logic [5:0]        cfg_size,
    input  logic [35:0]       cfg_lbase,
    input  logic [39:0]       cfg_pbase,
    input  logic              req_valid,
    input  logic              req_burst,
    input  logic [35:0]       req_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic              out_miss,
    output logic              out_is_io,
    output logic [1:0]        out_win,
    output logic              out_dac,
    output logic [39:0]       out_addr
);
    win_t [NWIN-1:0]  wins;
    logic             m_found;
    logic [WIN_W-1:0] m_sel;
    logic [PA_W-1:0]  m_addr;

    st_t              state, state_nxt;
    logic [PA_W-1:0]  r_addr;
    logic [WIN_W-1:0] r_win;
    logic             r_dac;
    logic             r_io;

    pwx_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_en    (cfg_en),
        .cfg_size  (cfg_size),
        .cfg_lbase (cfg_lbase),
        .cfg_pbase (cfg_pbase),
        .wins      (wins)
    );

    pwx_match u_match (
        .wins     (wins),
        .addr     (req_addr),
        .found    (m_found),
        .sel      (m_sel),
        .sel_addr (m_addr)
    );

    // next-state selection from this cycle's request
    always_comb begin
        state_nxt = S_IDLE;
        if (req_valid && req_burst)
            state_nxt = m_found ? S_HIT : S_MISS;
    end

    // state register and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            r_addr <= '0;
            r_win  <= '0;
            r_dac  <= 1'b0;
            r_io   <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state_nxt == S_HIT) begin
                r_addr <= m_addr;
                r_win  <= m_sel;
                r_dac  <= |m_addr[PA_W-1:32];
                r_io   <= (m_sel == WIN_W'(IO_WIN));
            end else begin
                r_addr <= '0;
                r_win  <= '0;
                r_dac  <= 1'b0;
                r_io   <= 1'b0;
            end
        end
    end

    // output decode
    always_comb begin
        out_valid = 1'b0;
        out_hit   = 1'b0;
        out_miss  = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_HIT: begin
                out_valid = 1'b1;
                out_hit   = 1'b1;
            end
            S_MISS: begin
                out_valid = 1'b1;
                out_miss  = 1'b1;
            end
            default: ;
        endcase
        out_addr  = r_addr;
        out_win   = r_win;
        out_dac   = r_dac;
        out_is_io = r_io;
    end

    AST_NO_WIN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst && !wins[0].en && !wins[1].en && !wins[2].en && !wins[3].en)
        |=> out_miss); // R8
    AST_NONBURST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_burst) |=> !out_valid); // R9
    AST_NOREQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R10
    AST_DAC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (out_dac == (out_addr > 40'h00_FFFF_FFFF))); // R7
    AST_IO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (out_is_io == (out_win == 2'd3))); // R6
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst) |=> (out_miss || out_addr[19:0] == $past(req_addr[19:0]))); // R3
    AST_WIN0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst && wins[0].en &&
         ((req_addr ^ wins[0].lbase) >> wins[0].sz) == '0) |=> (out_hit && out_win == 2'd0)); // R5
endmodule

// File: tb/sim_pci_window_xlate.sv
module sim_pci_window_xlate;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_en;
    logic [1:0]  cfg_sel;
    logic [5:0]  cfg_size;
    logic [35:0] cfg_lbase;
    logic [39:0] cfg_pbase;
    logic        req_valid, req_burst;
    logic [35:0] req_addr;
    logic        out_valid, out_hit, out_miss, out_is_io, out_dac;
    logic [1:0]  out_win;
    logic [39:0] out_addr;

    int total = 0;
    int bad   = 0;

    logic        sh_en [4];
    logic [5:0]  sh_sz [4];
    logic [35:0] sh_lb [4];
    logic [39:0] sh_pb [4];

    always #10 clk = ~clk;

    pci_window_xlate u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [35:0] a, output logic hit, output logic [1:0] w,
                         output logic [39:0] xa);
        hit = 1'b0; w = 2'd0; xa = '0;
        for (int i = 3; i >= 0; i--) begin
            logic [39:0] om;
            om = (40'd1 << sh_sz[i]) - 40'd1;
            if (sh_en[i] && ((({4'd0, a} ^ {4'd0, sh_lb[i]}) & ~om) == 40'd0)) begin
                hit = 1'b1; w = 2'(i);
                xa = (sh_pb[i] & ~om) | ({4'd0, a} & om);
            end
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic e, input logic [5:0] sz,
                      input logic [35:0] lb, input logic [39:0] pb);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_en = e; cfg_size = sz;
        cfg_lbase = lb; cfg_pbase = pb;
        @(negedge clk);
        cfg_we = 1'b0;
        sh_en[s] = e;
        sh_sz[s] = (sz < 6'd20) ? 6'd20 : (sz > 6'd36) ? 6'd36 : sz;
        sh_lb[s] = lb; sh_pb[s] = pb;
    endtask

    task automatic req_chk(input string tag, input logic [35:0] a);
        logic h; logic [1:0] w; logic [39:0] xa;
        model(a, h, w, xa);
        req_valid = 1'b1; req_burst = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 64'(out_valid), 64'd1);
        chk({tag, " hit"},   64'(out_hit),   64'(h));
        chk({tag, " miss"},  64'(out_miss),  64'(!h));
        if (h) begin
            chk({tag, " win"},  64'(out_win),   64'(w));
            chk({tag, " addr"}, 64'(out_addr),  64'(xa));
            chk({tag, " io"},   64'(out_is_io), 64'(w == 2'd3));
            chk({tag, " dac"},  64'(out_dac),   64'(xa > 40'h00_FFFF_FFFF));
        end
    endtask

    initial begin
        cfg_we = 0; cfg_sel = 0; cfg_en = 0; cfg_size = 0; cfg_lbase = 0; cfg_pbase = 0;
        req_valid = 0; req_burst = 0; req_addr = 0;
        for (int i = 0; i < 4; i++) begin
            sh_en[i] = 0; sh_sz[i] = 6'd20; sh_lb[i] = 0; sh_pb[i] = 0;
        end
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 idle after reset", 64'(out_valid), 64'd0);
        req_chk("R1 R8 all disabled", 36'h0_0000_0000);
        chk("R1 R8 miss flag", 64'(out_miss), 64'd1);

        // window 0 above 4 GiB
        wr(2'd0, 1'b1, 6'd24, 36'h2_3400_0000, 40'h12_0000_0000);
        req_chk("R2 R3 win0", 36'h2_3412_3456);
        chk("R3 R7 win0 addr", 64'(out_addr), 64'h12_0012_3456);
        chk("R7 dac set", 64'(out_dac), 64'd1);
        req_chk("R2 win0 outside", 36'h2_3500_0000);

        // size below minimum clamps to 1 MiB
        wr(2'd1, 1'b1, 6'd5, 36'h0_0050_0000, 40'h00_8000_0000);
        req_chk("R4 low clamp last byte", 36'h0_005F_FFFF);
        chk("R4 R7 low clamp addr", 64'(out_addr), 64'h00_800F_FFFF);
        chk("R7 dac clear", 64'(out_dac), 64'd0);
        req_chk("R4 low clamp edge", 36'h0_0060_0000);
        chk("R4 edge miss", 64'(out_miss), 64'd1);

        // size above maximum clamps to whole space
        wr(2'd2, 1'b1, 6'd50, 36'h0_0000_0000, 40'hA5_0000_0000);
        req_chk("R4 high clamp", 36'h7_0000_0000);
        chk("R4 R3 full window addr", 64'(out_addr), 64'hA7_0000_0000);
        chk("R5 win2 chosen", 64'(out_win), 64'd2);

        // priority and I/O window
        wr(2'd3, 1'b1, 6'd20, 36'h0_0050_0000, 40'h00_1000_0000);
        req_chk("R5 win1 over io", 36'h0_0050_0010);
        chk("R5 win1 idx", 64'(out_win), 64'd1);
        wr(2'd1, 1'b0, 6'd20, 36'h0_0050_0000, 40'h00_8000_0000);
        req_chk("R5 R11 win2 after win1 off", 36'h0_0050_0010);
        chk("R11 win2 idx", 64'(out_win), 64'd2);
        wr(2'd2, 1'b0, 6'd36, 36'h0, 40'hA5_0000_0000);
        req_chk("R6 io hit", 36'h0_0050_0010);
        chk("R6 io flag", 64'(out_is_io), 64'd1);
        chk("R6 io addr", 64'(out_addr), 64'h00_1000_0010);
        req_chk("R11 disabled win2 no hit", 36'h7_0000_0000);
        chk("R11 miss", 64'(out_miss), 64'd1);

        // non-burst and idle
        req_valid = 1'b1; req_burst = 1'b0; req_addr = 36'h0_0050_0010;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 non-burst ignored", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk("R10 no request idle", 64'(out_valid), 64'd0);

        // random
        begin
            int unsigned sd;
            sd = $urandom(32'd4937);
            for (int r = 0; r < 40; r++) begin
                for (int i = 0; i < 4; i++)
                    wr(2'(i), 1'($urandom % 4 != 0), 6'(18 + $urandom % 21),
                       {4'($urandom % 16), 32'($urandom)}, {8'($urandom % 4), 32'($urandom)});
                for (int k = 0; k < 20; k++) begin
                    logic [35:0] a;
                    int j;
                    j = $urandom % 5;
                    if (j < 4) a = sh_lb[j] ^ 36'($urandom % (1 << 22));
                    else       a = {4'($urandom % 16), 32'($urandom)};
                    req_chk("R2 R3 R5 R6 R7 R8 random", a);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R10 act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule